// File: doc/BRIEF.md
# Multi-Channel Converter Scan Sequencer Timer

This block paces a single shared converter through a scan of up to twenty-two channels: sixteen bipolar inputs (indices 0 to 15), five unipolar inputs (indices 16 to 20) and one internal temperature channel (index 21). A start pulse captures three enable masks and a 2-bit rate code. The block then visits each enabled channel in ascending index order. It holds each channel for a dwell time that depends on the channel's type and on the captured rate code. During the dwell it drives an acquire strobe and a convert strobe that mark the two phases of the conversion.

The two phases meet on a half-clock boundary, since the convert phase of a bipolar or unipolar channel is 13.5 clocks long. The block therefore counts in half-clock ticks, two per clock. The one clock that straddles the boundary shows both strobes high. When the last enabled channel is finished, the block pulses scan-complete and presents the total number of clocks the scan took. A controller can use that count to check the update rate.

Top module: `scan_seq_timer`

## Requirements
- R1: While reset is low and after it is released, busy, both phase strobes, channel-done and scan-complete are 0, and the cycle count is 0.
- R2: A scan visits every enabled channel exactly once, in ascending index order (bipolar 0..15, then unipolar 16..20, then temperature 21). Disabled channels take zero clocks, so each next channel starts in the clock right after the previous one ends.
- R3: A bipolar channel lasts 138 clocks for rate codes 2'b00, 2'b01 and 2'b10, and 276 clocks for 2'b11.
- R4: A unipolar channel lasts 46, 92, 138 or 276 clocks for rate codes 2'b00, 2'b01, 2'b10 and 2'b11 respectively.
- R5: The temperature channel lasts 1025 clocks for every rate code.
- R6: For a bipolar or unipolar channel of D clocks, convert is high in the last 14 clocks and acquire is high in the first D-13 clocks, so exactly one clock has both high. For the temperature channel, acquire is high for the whole dwell and convert never rises.
- R7: Channel-done is high in the last clock of each channel's dwell and at no other time.
- R8: Scan-complete is high for one clock, in the clock after the final channel ends, with busy low. The cycle count then equals the sum of the dwells of the enabled channels, and it holds until the next scan completes.
- R9: The masks and the rate code are sampled at the start pulse. Changing them during a scan does not change the order, the dwells or the count.
- R10: A start pulse received while busy is ignored.
- R11: A start with all masks clear gives scan-complete in the next clock with a count of 0, and busy never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a scan; ignored while busy |
| bip_en_i | input | 16 | Enable mask of bipolar channels 0..15 |
| uni_en_i | input | 5 | Enable mask of unipolar channels 16..20 |
| temp_en_i | input | 1 | Enable of temperature channel 21 |
| rate_i | input | 2 | Conversion-rate code |
| busy_o | output | 1 | A channel dwell is in progress |
| chan_o | output | 5 | Index of the current channel |
| acquire_o | output | 1 | Acquisition phase strobe |
| convert_o | output | 1 | Conversion phase strobe |
| chan_done_o | output | 1 | Last clock of the current channel |
| scan_done_o | output | 1 | One-clock scan-complete pulse |
| scan_cycles_o | output | 16 | Clock count of the last completed scan |

## Verification
Every single channel is scanned on its own at every rate code. This separates the three dwell tables and shows where the phase boundary falls for each type. Full masks and sparse masks at every rate show that skipped channels cost no clocks and that the total count matches the sum of the dwells. An empty mask exercises the immediate-completion path. A scan in which the masks and the rate change and a second start arrives mid-way shows that the captured configuration governs the whole scan.

// File: rtl/scan_seq_pkg.sv
// Shared constants, types and dwell arithmetic for the scan sequencer timer.
// Assumes the fixed channel split 16 bipolar / 5 unipolar / 1 temperature.
package scan_seq_pkg;

    localparam int NUM_BIP      = 16;
    localparam int NUM_UNI      = 5;
    localparam int NUM_CH       = NUM_BIP + NUM_UNI + 1;
    localparam int TEMP_IDX     = NUM_BIP + NUM_UNI;
    localparam int CH_W         = $clog2(NUM_CH);

    localparam int HALF_PER_CLK = 2;      // half ticks per clock
    localparam int CONV_HALF    = 27;     // convert phase, in half ticks

    localparam int DW_STD       = 138;    // clocks, common dwell
    localparam int DW_SLOW      = 276;    // clocks, slowest code
    localparam int DW_UNI_FAST  = 46;
    localparam int DW_UNI_MID   = 92;
    localparam int DW_TEMP      = 1025;

    localparam int HT_W         = $clog2(HALF_PER_CLK * DW_TEMP + 1);

    typedef enum logic [1:0] {
        RATE_FAST = 2'b00,
        RATE_MID  = 2'b01,
        RATE_STD  = 2'b10,
        RATE_SLOW = 2'b11
    } rate_t;

    typedef enum logic [1:0] {
        KIND_BIP,
        KIND_UNI,
        KIND_TEMP
    } kind_t;

    // Classify a channel index by its input type.
    function automatic kind_t kind_of(input logic [CH_W-1:0] idx);
        if (int'(idx) < NUM_BIP)
            return KIND_BIP;
        else if (int'(idx) < TEMP_IDX)
            return KIND_UNI;
        else
            return KIND_TEMP;
    endfunction

    // Dwell of a channel in half ticks, from its type and the rate code.
    function automatic logic [HT_W-1:0] dwell_half(input kind_t k, input rate_t r);
        int clks;
        case (k)
            KIND_BIP: clks = (r == RATE_SLOW) ? DW_SLOW : DW_STD;
            KIND_UNI: begin
                case (r)
                    RATE_FAST: clks = DW_UNI_FAST;
                    RATE_MID:  clks = DW_UNI_MID;
                    RATE_STD:  clks = DW_STD;
                    default:   clks = DW_SLOW;
                endcase
            end
            default:  clks = DW_TEMP;
        endcase
        return HT_W'(HALF_PER_CLK * clks);
    endfunction

endpackage

// File: rtl/scan_next_pick.sv
// Finds the lowest enabled channel above a given index, or the lowest
// enabled channel at all when from_valid is low. Purely combinational.
// Assumes N fits in W bits.
module scan_next_pick #(
    parameter int N = 22,
    parameter int W = 5
) (
    input  logic [N-1:0] en_i,
    input  logic [W-1:0] from_idx_i,
    input  logic         from_valid_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);

    logic [N-1:0] cand;

    // Qualify each enable by its position relative to the current index.
    for (genvar g = 0; g < N; g++) begin : g_cand
        assign cand[g] = en_i[g] && (!from_valid_i || (g > int'(from_idx_i)));
    end

    // Priority encoder: the lowest qualified index wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found_o = 1'b1;
                idx_o   = W'(i);
            end
        end
    end

endmodule

// File: rtl/scan_dwell_timer.sv
// Half-tick dwell counter for one channel. It advances two half ticks per
// clock while run is high and clears on restart. It flags the last clock of
// the dwell and derives the acquire and convert strobes. The clock that
// straddles the half-clock boundary shows both strobes.
// Assumes dwell_half_i is even, at least CONV_HALF+1, and stable within a
// channel.
module scan_dwell_timer
    import scan_seq_pkg::*;
#(
    parameter int TW = HT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          run_i,
    input  logic          is_temp_i,
    input  logic [TW-1:0] dwell_half_i,
    output logic          last_o,
    output logic          acq_o,
    output logic          conv_o
);

    localparam logic [TW-1:0] STEP      = TW'(HALF_PER_CLK);
    localparam logic [TW-1:0] CONV_EDGE = TW'(CONV_HALF);
    localparam logic [TW-1:0] CONV_OPEN = TW'(CONV_HALF + 1);

    logic [TW-1:0] ht_q;

    // Half-tick position within the current channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ht_q <= '0;
        else if (restart_i)
            ht_q <= '0;
        else if (run_i)
            ht_q <= ht_q + STEP;
    end

    // Phase decode: a clock covers half ticks [ht, ht+2).
    always_comb begin
        last_o = run_i && (ht_q == dwell_half_i - STEP);
        conv_o = run_i && !is_temp_i && (ht_q >= dwell_half_i - CONV_OPEN);
        acq_o  = run_i && (is_temp_i || (ht_q < dwell_half_i - CONV_EDGE));
    end

    // R7: the counter never passes the end of the dwell.
    p_ht_in_dwell_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (ht_q < dwell_half_i));

    // R6: once convert has begun it stays on until the channel ends.
    p_conv_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && conv_o && !last_o) |=> conv_o);

    // R6: once acquire has ended it does not come back within the channel.
    p_acq_stays_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !acq_o && !last_o) |=> !acq_o);

endmodule

// File: rtl/scan_cycle_acc.sv
// Running clock count of the scan in progress. Clears at launch and
// increments once per busy clock. Assumes CW covers the longest scan.
module scan_cycle_acc #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          inc_i,
    output logic [CW-1:0] sum_o
);

    // Count busy clocks since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_o <= '0;
        else if (clear_i)
            sum_o <= '0;
        else if (inc_i)
            sum_o <= sum_o + CW'(1);
    end

    // R8: the count does not wrap during a scan.
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clear_i) |=> (sum_o != '0));

endmodule

// File: rtl/scan_seq_timer.sv
// Scan sequencer timer. It captures the enable masks and the rate code at
// start, steps through the enabled channels in ascending order, times each
// dwell in half ticks and reports the total scan length. Starts received
// while busy are ignored. An empty mask completes at once.
// Assumes CNT_W can hold the longest scan (6821 clocks).
module scan_seq_timer
    import scan_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NUM_BIP-1:0]   bip_en_i,
    input  logic [NUM_UNI-1:0]   uni_en_i,
    input  logic                 temp_en_i,
    input  logic [1:0]           rate_i,
    output logic                 busy_o,
    output logic [CH_W-1:0]      chan_o,
    output logic                 acquire_o,
    output logic                 convert_o,
    output logic                 chan_done_o,
    output logic                 scan_done_o,
    output logic [CNT_W-1:0]     scan_cycles_o
);

    logic [NUM_CH-1:0] in_mask;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] pick_src;
    rate_t             rate_q;
    logic              running_q;
    logic [CH_W-1:0]   chan_q;
    logic              done_q;
    logic [CNT_W-1:0]  total_q;
    logic [CNT_W-1:0]  acc_sum;

    logic              launch;
    logic              step;
    logic              last_clk;
    logic              pick_found;
    logic [CH_W-1:0]   pick_idx;
    kind_t             kind_cur;
    logic [HT_W-1:0]   dwell_cur;

    // Concatenate the enable inputs into channel-index order.
    assign in_mask  = {temp_en_i, uni_en_i, bip_en_i};
    assign launch   = start_i && !running_q;
    assign step     = running_q && last_clk;
    assign pick_src = running_q ? en_q : in_mask;
    assign kind_cur = kind_of(chan_q);
    assign dwell_cur = dwell_half(kind_cur, rate_q);

    scan_next_pick #(
        .N (NUM_CH),
        .W (CH_W)
    ) u_pick (
        .en_i         (pick_src),
        .from_idx_i   (chan_q),
        .from_valid_i (running_q),
        .found_o      (pick_found),
        .idx_o        (pick_idx)
    );

    scan_dwell_timer #(
        .TW (HT_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (launch || step),
        .run_i        (running_q),
        .is_temp_i    (kind_cur == KIND_TEMP),
        .dwell_half_i (dwell_cur),
        .last_o       (last_clk),
        .acq_o        (acquire_o),
        .conv_o       (convert_o)
    );

    scan_cycle_acc #(
        .CW (CNT_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (launch),
        .inc_i   (running_q),
        .sum_o   (acc_sum)
    );

    // Scan control: capture at launch, advance at each channel end, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            chan_q    <= '0;
            en_q      <= '0;
            rate_q    <= RATE_FAST;
            done_q    <= 1'b0;
            total_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                en_q   <= in_mask;
                rate_q <= rate_t'(rate_i);
                if (pick_found) begin
                    running_q <= 1'b1;
                    chan_q    <= pick_idx;
                end else begin
                    done_q  <= 1'b1;
                    total_q <= '0;
                end
            end else if (step) begin
                if (pick_found) begin
                    chan_q <= pick_idx;
                end else begin
                    running_q <= 1'b0;
                    done_q    <= 1'b1;
                    total_q   <= acc_sum + CNT_W'(1);
                end
            end
        end
    end

    // Drive the outputs from the control state.
    assign busy_o        = running_q;
    assign chan_o        = chan_q;
    assign chan_done_o   = step;
    assign scan_done_o   = done_q;
    assign scan_cycles_o = total_q;

    // R2: the channel being timed is one the captured mask enables.
    p_chan_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> en_q[chan_q]);

    // R2: moving on always goes to a higher index.
    p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && pick_found) |=> (chan_q > $past(chan_q)));

    // R9/R10: mid-channel, the channel and the captured setup hold still.
    p_hold_setup_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !step) |=> (running_q && $stable(chan_q) &&
                                  $stable(en_q) && $stable(rate_q)));

    // R8: scan-complete never coincides with a running dwell.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !running_q);

endmodule

// File: tb/sim_scan_seq_timer.sv
module sim_scan_seq_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] bip_en_i = '0;
    logic [4:0]  uni_en_i = '0;
    logic        temp_en_i = 1'b0;
    logic [1:0]  rate_i = '0;
    logic        busy_o, acquire_o, convert_o, chan_done_o, scan_done_o;
    logic [4:0]  chan_o;
    logic [15:0] scan_cycles_o;

    int checks = 0;
    int errors = 0;

    // Scan context shared with the monitor.
    logic [NCH-1:0] cur_mask = '0;
    int  cur_rate = 0;
    int  prev_idx = -1;
    bit  in_chan = 0;
    bit  mon_en = 0;
    bit  overrun = 0;
    int  clk_cnt, acq_cnt, cnv_cnt, both_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_seq_timer u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .bip_en_i      (bip_en_i),
        .uni_en_i      (uni_en_i),
        .temp_en_i     (temp_en_i),
        .rate_i        (rate_i),
        .busy_o        (busy_o),
        .chan_o        (chan_o),
        .acquire_o     (acquire_o),
        .convert_o     (convert_o),
        .chan_done_o   (chan_done_o),
        .scan_done_o   (scan_done_o),
        .scan_cycles_o (scan_cycles_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_dwell(input int idx, input int rate);
        if (idx < 16) return (rate == 3) ? 276 : 138;
        if (idx < 21) begin
            case (rate)
                0: return 46;
                1: return 92;
                2: return 138;
                default: return 276;
            endcase
        end
        return 1025;
    endfunction

    function automatic int next_en(input logic [NCH-1:0] m, input int after);
        for (int i = after + 1; i < NCH; i++)
            if (m[i]) return i;
        return -1;
    endfunction

    function automatic string dwell_tag(input int idx);
        if (idx < 16) return "R3 bipolar dwell";
        if (idx < 21) return "R4 unipolar dwell";
        return "R5 temperature dwell";
    endfunction

    // Per-channel monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mon_en && rst_n && busy_o) begin
            if (!in_chan) begin
                chk(int'(chan_o) == next_en(cur_mask, prev_idx), "R2 channel order",
                    int'(chan_o), next_en(cur_mask, prev_idx));
                in_chan  = 1;
                overrun  = 0;
                clk_cnt  = 0;
                acq_cnt  = 0;
                cnv_cnt  = 0;
                both_cnt = 0;
            end
            clk_cnt++;
            acq_cnt  += int'(acquire_o);
            cnv_cnt  += int'(convert_o);
            both_cnt += int'(acquire_o && convert_o);
            if (chan_done_o) begin
                chk(clk_cnt == exp_dwell(int'(chan_o), cur_rate), dwell_tag(int'(chan_o)),
                    clk_cnt, exp_dwell(int'(chan_o), cur_rate));
                if (int'(chan_o) == 21) begin
                    chk(acq_cnt == 1025, "R6 temperature acquire clocks", acq_cnt, 1025);
                    chk(cnv_cnt == 0, "R6 temperature convert clocks", cnv_cnt, 0);
                end else begin
                    chk(acq_cnt == clk_cnt - 13, "R6 acquire clocks", acq_cnt, clk_cnt - 13);
                    chk(cnv_cnt == 14, "R6 convert clocks", cnv_cnt, 14);
                    chk(both_cnt == 1, "R6 overlap clocks", both_cnt, 1);
                end
                prev_idx = int'(chan_o);
                in_chan  = 0;
            end else if (!overrun && clk_cnt >= exp_dwell(int'(chan_o), cur_rate)) begin
                overrun = 1;
                chk(1'b0, "R7 channel-done missing at last clock", clk_cnt,
                    exp_dwell(int'(chan_o), cur_rate));
            end
        end
    end

    // Run one scan and check its completion; optionally disturb the inputs.
    task automatic run_scan(input logic [NCH-1:0] m, input int rate, input bit disturb);
        int exp_total = 0;
        int n = 0;
        for (int i = 0; i < NCH; i++)
            if (m[i]) exp_total += exp_dwell(i, rate);
        @(negedge clk);
        cur_mask  = m;
        cur_rate  = rate;
        prev_idx  = -1;
        in_chan   = 0;
        bip_en_i  = m[15:0];
        uni_en_i  = m[20:16];
        temp_en_i = m[21];
        rate_i    = 2'(rate);
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin
            bip_en_i  = ~m[15:0];
            uni_en_i  = ~m[20:16];
            temp_en_i = ~m[21];
            rate_i    = 2'(rate ^ 3);
        end
        if (m == '0) begin
            chk(scan_done_o == 1'b1, "R11 empty scan completes next clock", int'(scan_done_o), 1);
            chk(busy_o == 1'b0, "R11 empty scan stays idle", int'(busy_o), 0);
            chk(scan_cycles_o == 16'd0, "R11 empty scan count", int'(scan_cycles_o), 0);
            @(negedge clk);
            chk(scan_done_o == 1'b0 && busy_o == 1'b0, "R11 single pulse, no busy",
                int'(scan_done_o), 0);
            return;
        end
        while (!scan_done_o && n < 8000) begin
            @(negedge clk);
            n++;
            if (disturb && n == 3) start_i = 1'b1;
            if (disturb && n == 4) start_i = 1'b0;
        end
        chk(n == exp_total, "R2/R8 scan length in clocks", n, exp_total);
        chk(int'(scan_cycles_o) == exp_total,
            disturb ? "R9/R10 count after disturbed scan" : "R8 scan cycle count",
            int'(scan_cycles_o), exp_total);
        chk(busy_o == 1'b0, "R8 idle at scan-complete", int'(busy_o), 0);
        chk(next_en(m, prev_idx) == -1, "R2 all enabled channels visited",
            next_en(m, prev_idx), -1);
        @(negedge clk);
        chk(scan_done_o == 1'b0, "R8 scan-complete lasts one clock", int'(scan_done_o), 0);
        chk(int'(scan_cycles_o) == exp_total, "R8 count holds", int'(scan_cycles_o), exp_total);
        chk(busy_o == 1'b0, "R10 no restart from mid-scan start", int'(busy_o), 0);
    endtask

    // Global watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle while in reset.
        chk(!busy_o && !acquire_o && !convert_o && !chan_done_o && !scan_done_o,
            "R1 reset strobes", int'(busy_o), 0);
        chk(scan_cycles_o == 16'd0, "R1 reset count", int'(scan_cycles_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !scan_done_o && scan_cycles_o == 16'd0, "R1 idle after reset",
            int'(busy_o), 0);
        mon_en = 1;

        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < NCH; c++)
                run_scan(NCH'(1) << c, r, 0);
            run_scan('1, r, 0);
            run_scan('0, r, 0);
            run_scan(22'h2A_8421, r, 0);
            run_scan(22'h01_8000, r, 0);
        end
        run_scan(22'h31_0C03, 1, 1);
        run_scan(22'h1F_0001, 3, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule